// File: doc/BRIEF.md
# Crossbar Error Capture Unit

This unit collects fault events from the queues of an on-chip crossbar. There are two kinds of queue. Output queues report bad route selects, overflows, underflows and tail timeouts. Input queues report overflows and deadlock timeouts. Every event arrives separately for each of the two channels. For each queue the unit keeps a sticky error register. It also keeps one first-error record that names the kind, channel mask and source queue of the earliest fault. While that record is valid, an interrupt is raised toward two processor ports.

Software reaches the unit through a single-cycle register port. Reads are combinational. A write to a queue's error register injects the written bits as if hardware had reported them. Each queue register has its own clear address. The first-error record has a separate clear address, and that clear is accepted only after every queue register has been emptied. This enforces the clearing order: queue registers first, then the record.

Sources `0..NUM_OQ-1` are output queues. Sources `NUM_OQ..NUM_OQ+NUM_IQ-1` are input queues. An event vector bit `2*q+c` belongs to queue `q`, channel `c`.

Top module: `xbe_err_capture`

## Requirements
- R1: After reset, every queue error register and the first-error record read as zero, and all interrupt outputs are low.
- R2: In an output-queue register, channel c of each event sets one bit: bad select at bit c, overflow at bit 4+c, underflow at bit 8+c, tail timeout at bit 12+c. All other bits stay zero.
- R3: In an input-queue register, overflow sets bit c and deadlock timeout sets bit 4+c. All other bits stay zero.
- R4: Error bits are sticky. A later event ORs its bits in and never clears bits that are already set.
- R5: A write of any data to address CLR_BASE+s (default 16+s) zeroes register s. An event for that queue in the same cycle still sets its bits.
- R6: The first-error record reads at FE_ADDR (default 32) as type [3:0], channel mask [7:4], source [11:8] and valid at bit 12. It is captured only when valid is clear. Type codes are 1 bad select, 2 overflow, 3 underflow, 4 tail timeout and 5 deadlock timeout. Later errors leave the record unchanged.
- R7: When several errors start in one cycle, the lowest source index is recorded. Within that source, the lowest-positioned field is recorded, and its channel mask holds both channel bits of that field.
- R8: Every interrupt output equals the first-error valid bit.
- R9: A write to FE_CLR_ADDR (default 33) clears the record only if all queue registers are zero. If an error arrives in the same cycle as an accepted clear, that error is captured as the new record.
- R10: Writes to FE_ADDR have no effect on the record.
- R11: A write to address s (s below the source count) ORs the data, masked to that queue's defined bits, into register s and counts as an error for the first-error capture. A write with no defined bits has no effect.
- R12: Reads of unmapped addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| oq_inv_sel_i | input | 2*NUM_OQ | Output-queue bad-select events, bit 2q+c |
| oq_ovf_i | input | 2*NUM_OQ | Output-queue overflow events |
| oq_unf_i | input | 2*NUM_OQ | Output-queue underflow events |
| oq_tto_i | input | 2*NUM_OQ | Output-queue tail-timeout events |
| iq_ovf_i | input | 2*NUM_IQ | Input-queue overflow events |
| iq_dlk_i | input | 2*NUM_IQ | Input-queue deadlock-timeout events |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Combinational read data for reg_addr_i |
| irq_o | output | NUM_IRQ | Interrupt to each processor port |

## Verification
The capture path is exercised in several ways:
- Single events on one channel, which confirm bit placement for both queue kinds.
- Simultaneous events across sources and within one source, which separate the source priority from the field priority.
- Clears issued in the wrong order and in the right order, which show that the record outlives the queue registers until they are all empty.
- Injected writes, including a write that carries only undefined bits.
- Two same-cycle collisions: a clear with an event, and an accepted record clear with a new error. These expose whether set wins over clear and whether a fresh error is lost.

// File: rtl/xbe_pkg.sv
package xbe_pkg;

  localparam int REG_W = 16;
  localparam logic [REG_W-1:0] OQ_MASK = 16'h3333;
  localparam logic [REG_W-1:0] IQ_MASK = 16'h0033;

  typedef enum logic [3:0] {
    ERR_NONE    = 4'd0,
    ERR_INV_SEL = 4'd1,
    ERR_OVF     = 4'd2,
    ERR_UNF     = 4'd3,
    ERR_TAIL_TO = 4'd4,
    ERR_DLK_TO  = 4'd5
  } err_type_e;

  typedef struct packed {
    logic      valid;
    logic [3:0] source;
    logic [3:0] channel;
    err_type_e etype;
  } first_err_t;

  localparam int FE_W = $bits(first_err_t);

  function automatic err_type_e field_type(input logic is_out, input int fld);
    err_type_e t;
    t = ERR_NONE;
    if (is_out) begin
      case (fld)
        0: t = ERR_INV_SEL;
        1: t = ERR_OVF;
        2: t = ERR_UNF;
        3: t = ERR_TAIL_TO;
        default: t = ERR_NONE;
      endcase
    end else begin
      case (fld)
        0: t = ERR_OVF;
        1: t = ERR_DLK_TO;
        default: t = ERR_NONE;
      endcase
    end
    return t;
  endfunction

endpackage

// File: rtl/xbe_rst_sync.sv
module xbe_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/xbe_qerr_reg.sv
module xbe_qerr_reg
  import xbe_pkg::*;
#(
  parameter bit IS_OUT = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [REG_W-1:0] hw_evt_i,
  input  logic             inj_i,
  input  logic [REG_W-1:0] inj_data_i,
  input  logic             clr_i,
  output logic [REG_W-1:0] err_o,
  output logic [REG_W-1:0] new_o
);
  localparam logic [REG_W-1:0] MASK = IS_OUT ? OQ_MASK : IQ_MASK;

  logic [REG_W-1:0] err_q, err_d, new_bits;
  logic             upd_en;

  always_comb begin
    new_bits = (hw_evt_i | (inj_i ? inj_data_i : '0)) & MASK;
    err_d    = (clr_i ? '0 : err_q) | new_bits;
    upd_en   = clr_i | (new_bits != '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     err_q <= '0;
    else if (upd_en) err_q <= err_d;
  end

  assign err_o = err_q;
  assign new_o = new_bits;
endmodule

// File: rtl/xbe_first_err.sv
module xbe_first_err
  import xbe_pkg::*;
#(
  parameter int NUM_OQ = 4,
  parameter int NSRC   = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NSRC-1:0][REG_W-1:0] new_i,
  input  logic                       clr_req_i,
  input  logic                       errs_zero_i,
  output first_err_t                 rec_o,
  output logic                       clr_ok_o
);
  first_err_t rec_q, rec_d, cand;
  logic       hit, capture, clr_ok, upd_en;

  // Scan from the highest source down so the lowest index is written last.
  always_comb begin
    hit  = 1'b0;
    cand = '0;
    for (int s = NSRC - 1; s >= 0; s--) begin
      if (new_i[s] != '0) begin
        hit          = 1'b1;
        cand.valid   = 1'b1;
        cand.source  = 4'(s);
        for (int f = 3; f >= 0; f--) begin
          if (new_i[s][4*f +: 2] != 2'b00) begin
            cand.channel = {2'b00, new_i[s][4*f +: 2]};
            cand.etype   = field_type(s < NUM_OQ, f);
          end
        end
      end
    end
  end

  always_comb begin
    clr_ok  = rec_q.valid & clr_req_i & errs_zero_i;
    capture = hit & (~rec_q.valid | clr_ok);
    upd_en  = capture | clr_ok;
    if (capture)     rec_d = cand;
    else if (clr_ok) rec_d = '0;
    else             rec_d = rec_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rec_q <= '0;
    else if (upd_en) rec_q <= rec_d;
  end

  assign rec_o    = rec_q;
  assign clr_ok_o = clr_ok;
endmodule

// File: rtl/xbe_reg_dec.sv
module xbe_reg_dec
  import xbe_pkg::*;
#(
  parameter int NSRC        = 8,
  parameter int ADDR_W      = 6,
  parameter int CLR_BASE    = 16,
  parameter int FE_ADDR     = 32,
  parameter int FE_CLR_ADDR = 33
) (
  input  logic                       wr_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [NSRC-1:0][REG_W-1:0] err_i,
  input  first_err_t                 rec_i,
  output logic [NSRC-1:0]            inj_o,
  output logic [NSRC-1:0]            clr_o,
  output logic                       fe_clr_o,
  output logic [REG_W-1:0]           rdata_o
);
  for (genvar s = 0; s < NSRC; s++) begin : g_dec
    assign inj_o[s] = wr_i && (addr_i == ADDR_W'(s));
    assign clr_o[s] = wr_i && (addr_i == ADDR_W'(CLR_BASE + s));
  end

  assign fe_clr_o = wr_i && (addr_i == ADDR_W'(FE_CLR_ADDR));

  always_comb begin
    rdata_o = '0;
    for (int s = 0; s < NSRC; s++) begin
      if (addr_i == ADDR_W'(s)) rdata_o = err_i[s];
    end
    if (addr_i == ADDR_W'(FE_ADDR)) rdata_o = {{(REG_W-FE_W){1'b0}}, rec_i};
  end
endmodule

// File: rtl/xbe_err_capture.sv
module xbe_err_capture
  import xbe_pkg::*;
#(
  parameter int NUM_OQ      = 4,
  parameter int NUM_IQ      = 4,
  parameter int NUM_IRQ     = 2,
  parameter int ADDR_W      = 6,
  parameter int CLR_BASE    = 16,
  parameter int FE_ADDR     = 32,
  parameter int FE_CLR_ADDR = 33
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [2*NUM_OQ-1:0]   oq_inv_sel_i,
  input  logic [2*NUM_OQ-1:0]   oq_ovf_i,
  input  logic [2*NUM_OQ-1:0]   oq_unf_i,
  input  logic [2*NUM_OQ-1:0]   oq_tto_i,
  input  logic [2*NUM_IQ-1:0]   iq_ovf_i,
  input  logic [2*NUM_IQ-1:0]   iq_dlk_i,
  input  logic                  reg_wr_i,
  input  logic [ADDR_W-1:0]     reg_addr_i,
  input  logic [15:0]           reg_wdata_i,
  output logic [15:0]           reg_rdata_o,
  output logic [NUM_IRQ-1:0]    irq_o
);
  localparam int NSRC = NUM_OQ + NUM_IQ;

  logic                       rst_n_sync;
  logic [NSRC-1:0][REG_W-1:0] hw_evt, err_arr, new_arr;
  logic [NSRC-1:0]            inj_vec, clr_vec;
  logic                       fe_clr_req, fe_clr_ok, errs_zero;
  logic                       clr_any, new_any;
  logic [NSRC*REG_W-1:0]      err_flat;
  first_err_t                 fe_rec;

  xbe_rst_sync u_rst_sync (.clk_i(clk_i), .rst_ni(rst_ni), .rst_no(rst_n_sync));

  for (genvar q = 0; q < NUM_OQ; q++) begin : g_oq_evt
    assign hw_evt[q] = {2'b00, oq_tto_i[2*q +: 2], 2'b00, oq_unf_i[2*q +: 2],
                        2'b00, oq_ovf_i[2*q +: 2], 2'b00, oq_inv_sel_i[2*q +: 2]};
  end
  for (genvar q = 0; q < NUM_IQ; q++) begin : g_iq_evt
    assign hw_evt[NUM_OQ+q] = {10'b0, iq_dlk_i[2*q +: 2], 2'b00, iq_ovf_i[2*q +: 2]};
  end

  for (genvar s = 0; s < NSRC; s++) begin : g_q
    xbe_qerr_reg #(.IS_OUT(s < NUM_OQ)) u_qerr (
      .clk_i     (clk_i),
      .rst_ni    (rst_n_sync),
      .hw_evt_i  (hw_evt[s]),
      .inj_i     (inj_vec[s]),
      .inj_data_i(reg_wdata_i),
      .clr_i     (clr_vec[s]),
      .err_o     (err_arr[s]),
      .new_o     (new_arr[s])
    );
  end

  assign err_flat  = err_arr;
  assign errs_zero = (err_flat == '0);
  assign clr_any   = |clr_vec;
  assign new_any   = |new_arr;

  xbe_reg_dec #(
    .NSRC(NSRC), .ADDR_W(ADDR_W), .CLR_BASE(CLR_BASE),
    .FE_ADDR(FE_ADDR), .FE_CLR_ADDR(FE_CLR_ADDR)
  ) u_dec (
    .wr_i    (reg_wr_i),
    .addr_i  (reg_addr_i),
    .err_i   (err_arr),
    .rec_i   (fe_rec),
    .inj_o   (inj_vec),
    .clr_o   (clr_vec),
    .fe_clr_o(fe_clr_req),
    .rdata_o (reg_rdata_o)
  );

  xbe_first_err #(.NUM_OQ(NUM_OQ), .NSRC(NSRC)) u_first (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_sync),
    .new_i      (new_arr),
    .clr_req_i  (fe_clr_req),
    .errs_zero_i(errs_zero),
    .rec_o      (fe_rec),
    .clr_ok_o   (fe_clr_ok)
  );

  assign irq_o = {NUM_IRQ{fe_rec.valid}};
endmodule

// File: rtl/xbe_err_capture_chk.sv
module xbe_err_capture_chk #(
  parameter int NUM_OQ  = 4,
  parameter int NUM_IQ  = 4,
  parameter int NUM_IRQ = 2,
  parameter int FE_W    = 13
) (
  input logic                          clk_i,
  input logic                          rst_n,
  input logic [NUM_IRQ-1:0]            irq_i,
  input logic [(NUM_OQ+NUM_IQ)*16-1:0] err_flat_i,
  input logic [FE_W-1:0]               fe_rec_i,
  input logic                          fe_clr_ok_i,
  input logic                          clr_any_i,
  input logic                          new_any_i
);
  logic fe_valid;
  assign fe_valid = fe_rec_i[FE_W-1];

  // R8
  irq_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(irq_i[0]) |-> $past(new_any_i));

  // R4
  sticky_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    !$past(clr_any_i) |-> ((err_flat_i & $past(err_flat_i)) == $past(err_flat_i)));

  // R6
  fe_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    ($past(fe_valid) && !$past(fe_clr_ok_i)) |-> $stable(fe_rec_i));

  // R9
  fe_order_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    $fell(fe_valid) |-> (err_flat_i == '0));

  // R9
  err_needs_fe_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (err_flat_i != '0) |-> fe_valid);
endmodule

bind xbe_err_capture xbe_err_capture_chk #(
  .NUM_OQ(NUM_OQ), .NUM_IQ(NUM_IQ), .NUM_IRQ(NUM_IRQ), .FE_W(13)
) u_chk (
  .clk_i      (clk_i),
  .rst_n      (rst_n_sync),
  .irq_i      (irq_o),
  .err_flat_i (err_flat),
  .fe_rec_i   (fe_rec),
  .fe_clr_ok_i(fe_clr_ok),
  .clr_any_i  (clr_any),
  .new_any_i  (new_any)
);

// File: tb/xbe_err_capture_bench.sv
module xbe_err_capture_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  inv, ovf, unf, tto, iovf, idlk;
  logic        wr;
  logic [5:0]  addr;
  logic [15:0] wdata, rdata;
  logic [1:0]  irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  typedef struct {
    logic [15:0] exp_data;
    logic [1:0]  exp_irq;
    string       tag;
  } sb_item_t;
  sb_item_t sb[$];

  always #2 clk = ~clk;

  xbe_err_capture u_xbe_err_capture (
    .clk_i(clk), .rst_ni(rst_n),
    .oq_inv_sel_i(inv), .oq_ovf_i(ovf), .oq_unf_i(unf), .oq_tto_i(tto),
    .iq_ovf_i(iovf), .iq_dlk_i(idlk),
    .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  // monitor: compares after each edge
  always begin
    @(posedge clk);
    #1;
    if (sb.size() > 0) begin
      sb_item_t it;
      it = sb.pop_front();
      n_checks++;
      if (rdata !== it.exp_data || irq !== it.exp_irq) begin
        n_fail++;
        $display("FAIL %s: actual data %h irq %b, expected data %h irq %b",
                 it.tag, rdata, irq, it.exp_data, it.exp_irq);
      end
    end
  end

  task automatic step(input logic w, input logic [5:0] a, input logic [15:0] d,
                      input logic [7:0] e_inv, input logic [7:0] e_ovf,
                      input logic [7:0] e_unf, input logic [7:0] e_tto,
                      input logic [7:0] e_iovf, input logic [7:0] e_idlk);
    @(negedge clk);
    wr = w; addr = a; wdata = d;
    inv = e_inv; ovf = e_ovf; unf = e_unf; tto = e_tto; iovf = e_iovf; idlk = e_idlk;
    @(negedge clk);
    wr = 0; wdata = '0;
    inv = '0; ovf = '0; unf = '0; tto = '0; iovf = '0; idlk = '0;
  endtask

  task automatic wreg(input logic [5:0] a, input logic [15:0] d);
    step(1'b1, a, d, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic chk(input logic [5:0] a, input logic [15:0] d, input logic [1:0] i,
                     input string tag);
    sb_item_t it;
    @(negedge clk);
    addr = a;
    it.exp_data = d; it.exp_irq = i; it.tag = tag;
    sb.push_back(it);
    @(posedge clk);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual hung, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; wr = 0; addr = '0; wdata = '0;
    inv = '0; ovf = '0; unf = '0; tto = '0; iovf = '0; idlk = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(6'd0,  16'h0000, 2'b00, "R1 err0 after reset");
    chk(6'd7,  16'h0000, 2'b00, "R1 err7 after reset");
    chk(6'd32, 16'h0000, 2'b00, "R1 first-error after reset");

    // R2 / R6 / R8 overflow on queue 2 channel 1
    step(0, 0, 0, 8'h00, 8'h20, 8'h00, 8'h00, 8'h00, 8'h00);
    chk(6'd2,  16'h0020, 2'b11, "R2 oq overflow bit");
    chk(6'd32, 16'h1222, 2'b11, "R6 first-error record");

    // R3 deadlock on input queue 1 (source 5) channel 0, record unchanged
    step(0, 0, 0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h04);
    chk(6'd5,  16'h0010, 2'b11, "R3 iq deadlock bit");
    chk(6'd32, 16'h1222, 2'b11, "R6 later error does not overwrite");

    // R9 clearing order
    wreg(6'd33, 16'h0000);
    chk(6'd32, 16'h1222, 2'b11, "R9 early clear refused");
    wreg(6'd18, 16'h0000);
    chk(6'd2,  16'h0000, 2'b11, "R5 per-queue clear");
    wreg(6'd33, 16'h0000);
    chk(6'd32, 16'h1222, 2'b11, "R9 clear refused with one register set");
    wreg(6'd21, 16'h0000);
    wreg(6'd33, 16'h0000);
    chk(6'd32, 16'h0000, 2'b00, "R9 clear accepted, R8 irq drops");

    // R4 sticky OR, R10 read-only record
    step(0, 0, 0, 8'h00, 8'h00, 8'h01, 8'h00, 8'h00, 8'h00);
    step(0, 0, 0, 8'h00, 8'h00, 8'h00, 8'h02, 8'h00, 8'h00);
    chk(6'd0,  16'h2100, 2'b11, "R4 sticky accumulation");
    wreg(6'd32, 16'hFFFF);
    chk(6'd32, 16'h1013, 2'b11, "R10 write to record ignored");
    wreg(6'd16, 16'h0000);
    wreg(6'd33, 16'h0000);

    // R7 source priority
    step(0, 0, 0, 8'h40, 8'h04, 8'h00, 8'h00, 8'h03, 8'h00);
    chk(6'd32, 16'h1112, 2'b11, "R7 lowest source wins");
    chk(6'd4,  16'h0003, 2'b11, "R3 iq overflow both channels");
    chk(6'd3,  16'h0001, 2'b11, "R2 oq bad-select bit");
    wreg(6'd17, 0); wreg(6'd19, 0); wreg(6'd20, 0); wreg(6'd33, 0);
    chk(6'd32, 16'h0000, 2'b00, "R9 record cleared after queue clears");

    // R7 field priority inside one source
    step(0, 0, 0, 8'h20, 8'h00, 8'h10, 8'h00, 8'h00, 8'h00);
    chk(6'd32, 16'h1221, 2'b11, "R7 lowest field wins");
    chk(6'd2,  16'h0102, 2'b11, "R2 two fields set");
    wreg(6'd18, 0); wreg(6'd33, 0);

    // R11 injection
    wreg(6'd6, 16'hFFFF);
    chk(6'd6,  16'h0033, 2'b11, "R11 inject masked for input queue");
    chk(6'd32, 16'h1632, 2'b11, "R11 inject sets record");
    wreg(6'd1, 16'hFFFF);
    chk(6'd1,  16'h3333, 2'b11, "R11 inject masked for output queue");
    wreg(6'd17, 0); wreg(6'd22, 0); wreg(6'd33, 0);
    wreg(6'd0, 16'hCCCC);
    chk(6'd0,  16'h0000, 2'b00, "R11 undefined-only write ignored");
    chk(6'd32, 16'h0000, 2'b00, "R11 undefined-only write sets no record");

    // R12 unmapped read
    wreg(6'd4, 16'h0001);
    chk(6'd10, 16'h0000, 2'b11, "R12 unmapped read");
    wreg(6'd20, 0); wreg(6'd33, 0);

    // R5 set wins over clear in the same cycle
    step(0, 0, 0, 8'h00, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00);
    step(1, 6'd16, 0, 8'h00, 8'h00, 8'h02, 8'h00, 8'h00, 8'h00);
    chk(6'd0,  16'h0200, 2'b11, "R5 clear with same-cycle event");
    chk(6'd32, 16'h1012, 2'b11, "R6 record kept through queue clear");

    // R9 accepted clear with same-cycle error recaptures
    wreg(6'd16, 0);
    step(1, 6'd33, 0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h80);
    chk(6'd32, 16'h1725, 2'b11, "R9 recapture on accepted clear");
    chk(6'd7,  16'h0020, 2'b11, "R3 deadlock channel 1");

    repeat (2) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule